// File: doc/BRIEF.md
# Port Word-Width Matcher with Byte Reversal

This block joins a port that moves 9-bit, 18-bit or 36-bit quantities to a FIFO whose words are always 36 bits (four 9-bit lanes). On the write side, narrow accesses are gathered into one full word, and a single push is raised only on the access that completes that word. On the read side, the first access of each word pops a word from the FIFO. That access and the ones that follow hand the word out lane by lane through a shift register. One 36-bit mode swaps the four lanes end-for-end in both directions, which converts between big-endian and little-endian order.

Pack progress and unpack progress are held apart. The port may therefore turn from writing to reading, or back, after any partial access, and each direction resumes where it stopped. The width select may change between whole words without a reset. An access that would have to push into a full FIFO, or pop from an empty one, is dropped and leaves all progress unchanged.

Top module: `port_width_matcher`

## Requirements
- R1: `wsel` selects the port width: 2'b11 is 36-bit, 2'b10 is 36-bit with lane reversal, 2'b01 is 18-bit using `port_wdata[17:0]`/`port_rdata[17:0]`, and 2'b00 is 9-bit using bits [8:0]. Unused upper read bits are zero.
- R2: In 36-bit mode, a write strobe with `fifo_full` low raises `fifo_push` in the same cycle, with `fifo_push_data` equal to `port_wdata`.
- R3: In reversed mode, a pushed word carries input lane 3-i in lane i, where lane i is bits [9i+8:9i].
- R4: In 18-bit mode, two writes form one word. The first write supplies lanes 1:0 and the second supplies lanes 3:2. The push occurs only on the second write.
- R5: In 9-bit mode, four writes form one word, filled from lane 0 upward. The push occurs only on the fourth write.
- R6: A read strobe pops only on the first access of a word. `port_rdata` is registered: it shows the access's data from the cycle after the strobe. In 36-bit mode that data is the popped word.
- R7: In reversed mode, a read returns the popped word with lane i taken from popped lane 3-i.
- R8: In 18-bit and 9-bit modes, successive reads return the lanes of the popped word from lane 0 upward, with no further pops until the word is used up.
- R9: Reads interleaved with a partially packed write word, and writes interleaved with a partially unpacked read word, leave both in progress unharmed.
- R10: A write that completes a word while `fifo_full` is high is ignored. There is no push, and the pack position does not advance, so a retry later completes the same word.
- R11: A read that needs a pop while `fifo_empty` is high is ignored. There is no pop, `port_rdata` is unchanged, and the unpack position does not advance.
- R12: `wsel` may change between complete words without a reset, and the next word is handled in the new mode.
- R13: While `rst_n` is low, `fifo_push` and `fifo_pop` stay low. After reset, `port_rdata` is zero and both directions start at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wsel | input | 2 | Port width select (see R1) |
| dir_rd | input | 1 | 1 = read access, 0 = write access |
| strobe | input | 1 | One access per cycle while high |
| port_wdata | input | 36 | Write data from the port |
| port_rdata | output | 36 | Registered read data to the port |
| fifo_push | output | 1 | Push one word into the FIFO |
| fifo_push_data | output | 36 | Word to push |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_pop | output | 1 | Take one word from the FIFO |
| fifo_pop_data | input | 36 | Word at the FIFO head, valid while not empty |
| fifo_empty | input | 1 | FIFO holds no word |

## Verification
Every lane value in the stimulus is distinct and ordered, so a lane landing in the wrong position or a swapped half shows up directly in the pushed or returned word. The four widths run back to back, which also covers mode changes at word boundaries. Changing the head-of-FIFO value on reads that must not pop tells a correct unpacker from one that fetches again. Interleaved partial reads and writes separate shared progress state from independent state. Full and empty retries show whether a refused access advanced the position.

// File: rtl/pwm_pkg.sv
// Shared types for the port word-width matcher.
// Assumes the two width-select bits map directly onto the mode codes.
package pwm_pkg;
    typedef enum logic [1:0] {
        MODE_BYTE     = 2'b00,
        MODE_HALF     = 2'b01,
        MODE_WIDE_REV = 2'b10,
        MODE_WIDE     = 2'b11
    } pwm_mode_e;
endpackage

// File: rtl/pwm_mode_decode.sv
// Turns the width select into the lanes moved per access, a wide flag
// and a reverse flag. Assumes LANES is even.
module pwm_mode_decode #(
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(LANES) + 1
) (
    input  logic [1:0]       wsel,
    output logic [CNT_W-1:0] step,
    output logic             wide,
    output logic             rev
);
    import pwm_pkg::*;

    pwm_mode_e mode;
    assign mode = pwm_mode_e'(wsel);

    // Decode the mode into per-access lane count and flags.
    always_comb begin
        step = CNT_W'(LANES);
        wide = 1'b1;
        rev  = 1'b0;
        case (mode)
            MODE_BYTE: begin
                step = CNT_W'(1);
                wide = 1'b0;
            end
            MODE_HALF: begin
                step = CNT_W'(LANES / 2);
                wide = 1'b0;
            end
            MODE_WIDE_REV: rev = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_lane_swap.sv
// Reverses the order of the lanes of a word (lane i <- lane LANES-1-i).
// Pure wiring; no assumptions beyond the parameters.
module pwm_lane_swap #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = din[(LANES-1-i)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pwm_packer.sv
// Collects narrow writes into a full word, lane 0 first, and pushes it on
// the access that completes it. Wide mode pushes each write directly.
// Assumes LANES is a power of two and that the step divides LANES.
module pwm_packer #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int CNT_W  = $clog2(LANES) + 1,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [CNT_W-1:0]  step,
    input  logic              wide,
    input  logic [WORD_W-1:0] wdata,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  end_pos;
    logic [WORD_W-1:0] pack_q;
    logic [WORD_W-1:0] merged;
    logic              complete;

    assign end_pos  = cnt_q + step;
    assign complete = wide || (end_pos >= CNT_W'(LANES));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        logic [CNT_W-1:0] src;
        logic [IDX_W-1:0] src_l;
        logic             in_win;
        assign src    = IDX - cnt_q;
        assign src_l  = src[IDX_W-1:0];
        assign in_win = (IDX >= cnt_q) && (IDX < end_pos);
        assign merged[i*LANE_W +: LANE_W] =
            in_win ? wdata[src_l*LANE_W +: LANE_W] : pack_q[i*LANE_W +: LANE_W];
    end

    assign push      = acc && complete && !fifo_full;
    assign push_data = wide ? wdata : merged;

    // Advance pack position; a refused completing write changes nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pack_q <= '0;
        end else if (acc) begin
            if (complete) begin
                if (!fifo_full) cnt_q <= '0;
            end else begin
                cnt_q  <= end_pos;
                pack_q <= merged;
            end
        end
    end
endmodule

// File: rtl/pwm_unpacker.sv
// Pops a word on the first read access of each word and hands it out
// lane 0 first through a shift register into a registered read port.
// Assumes the FIFO head word is valid whenever fifo_empty is low.
module pwm_unpacker #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int CNT_W  = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [CNT_W-1:0]  step,
    input  logic              wide,
    input  logic [WORD_W-1:0] pop_word,
    input  logic              fifo_empty,
    output logic              pop,
    output logic [WORD_W-1:0] rdata
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  end_pos;
    logic [CNT_W-1:0]  cnt_next;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] rd_q;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] masked;
    logic              need_fetch;
    logic              take;

    assign need_fetch = wide || (cnt_q == '0);
    assign pop        = acc && need_fetch && !fifo_empty;
    assign take       = acc && (!need_fetch || !fifo_empty);
    assign src        = need_fetch ? pop_word : sh_q;
    assign end_pos    = (need_fetch ? '0 : cnt_q) + step;
    assign cnt_next   = (end_pos >= CNT_W'(LANES)) ? '0 : end_pos;

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        assign masked[i*LANE_W +: LANE_W] =
            (IDX < step) ? src[i*LANE_W +: LANE_W] : '0;
    end

    // Deliver the next lanes and shift the remainder down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            rd_q  <= '0;
        end else if (take) begin
            rd_q  <= masked;
            sh_q  <= src >> (step * LANE_W);
            cnt_q <= cnt_next;
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/port_width_matcher.sv
// Top level: matches a 9/18/36-bit port to a full-word FIFO, with an
// optional lane-reversal mode. Assumes at most one access per cycle and
// width changes only between complete words.
module port_width_matcher #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int CNT_W  = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wsel,
    input  logic              dir_rd,
    input  logic              strobe,
    input  logic [WORD_W-1:0] port_wdata,
    output logic [WORD_W-1:0] port_rdata,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_push_data,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [WORD_W-1:0] fifo_pop_data,
    input  logic              fifo_empty
);
    logic [CNT_W-1:0]  step;
    logic              wide;
    logic              rev;
    logic              wr_acc;
    logic              rd_acc;
    logic [WORD_W-1:0] wdata_sw;
    logic [WORD_W-1:0] pop_sw;
    logic [WORD_W-1:0] wdata_eff;
    logic [WORD_W-1:0] pop_eff;

    assign wr_acc    = rst_n && strobe && !dir_rd;
    assign rd_acc    = rst_n && strobe && dir_rd;
    assign wdata_eff = rev ? wdata_sw : port_wdata;
    assign pop_eff   = rev ? pop_sw : fifo_pop_data;

    pwm_mode_decode #(.LANES(LANES)) u_dec (
        .wsel (wsel),
        .step (step),
        .wide (wide),
        .rev  (rev)
    );

    pwm_lane_swap #(.LANE_W(LANE_W), .LANES(LANES)) u_swap_wr (
        .din  (port_wdata),
        .dout (wdata_sw)
    );

    pwm_lane_swap #(.LANE_W(LANE_W), .LANES(LANES)) u_swap_rd (
        .din  (fifo_pop_data),
        .dout (pop_sw)
    );

    pwm_packer #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (wr_acc),
        .step      (step),
        .wide      (wide),
        .wdata     (wdata_eff),
        .fifo_full (fifo_full),
        .push      (fifo_push),
        .push_data (fifo_push_data)
    );

    pwm_unpacker #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (rd_acc),
        .step       (step),
        .wide       (wide),
        .pop_word   (pop_eff),
        .fifo_empty (fifo_empty),
        .pop        (fifo_pop),
        .rdata      (port_rdata)
    );
endmodule

// File: rtl/pwm_checker.sv
// Port-level properties of the word-width matcher, bound to the top.
module pwm_checker #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        wsel,
    input logic              dir_rd,
    input logic              strobe,
    input logic [WORD_W-1:0] port_wdata,
    input logic [WORD_W-1:0] port_rdata,
    input logic              fifo_push,
    input logic [WORD_W-1:0] fifo_push_data,
    input logic              fifo_full,
    input logic              fifo_pop,
    input logic [WORD_W-1:0] fifo_pop_data,
    input logic              fifo_empty
);
    p_quiet_reset_r13: assert property (@(posedge clk)
        !rst_n |-> (!fifo_push && !fifo_pop));

    p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push);

    p_no_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

    p_push_is_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (strobe && !dir_rd));

    p_pop_is_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (strobe && dir_rd));

    p_wide_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !dir_rd && wsel == 2'b11 && !fifo_full)
        |-> (fifo_push && fifo_push_data == port_wdata));

    p_rev_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && wsel == 2'b10)
        |-> (fifo_push_data[LANE_W-1:0] == port_wdata[WORD_W-1 -: LANE_W]));

    p_wide_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && wsel == 2'b11) |=> (port_rdata == $past(fifo_pop_data)));

    p_byte_read_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && dir_rd && wsel == 2'b00 && !fifo_empty)
        |=> (port_rdata[WORD_W-1:LANE_W] == '0));
endmodule

bind port_width_matcher pwm_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wsel           (wsel),
    .dir_rd         (dir_rd),
    .strobe         (strobe),
    .port_wdata     (port_wdata),
    .port_rdata     (port_rdata),
    .fifo_push      (fifo_push),
    .fifo_push_data (fifo_push_data),
    .fifo_full      (fifo_full),
    .fifo_pop       (fifo_pop),
    .fifo_pop_data  (fifo_pop_data),
    .fifo_empty     (fifo_empty)
);

// File: tb/port_width_matcher_test.sv
module port_width_matcher_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wsel = 2'b11;
    logic        dir_rd = 1'b0;
    logic        strobe = 1'b0;
    logic [35:0] port_wdata = '0;
    logic [35:0] port_rdata;
    logic        fifo_push;
    logic [35:0] fifo_push_data;
    logic        fifo_full = 1'b0;
    logic        fifo_pop;
    logic [35:0] fifo_pop_data = '0;
    logic        fifo_empty = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic        g_push, g_pop;
    logic [35:0] g_pdata, g_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_width_matcher uut (
        .clk(clk), .rst_n(rst_n), .wsel(wsel), .dir_rd(dir_rd), .strobe(strobe),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .fifo_push(fifo_push), .fifo_push_data(fifo_push_data), .fifo_full(fifo_full),
        .fifo_pop(fifo_pop), .fifo_pop_data(fifo_pop_data), .fifo_empty(fifo_empty)
    );

    localparam logic [35:0] D1  = {9'h104, 9'h103, 9'h102, 9'h101};
    localparam logic [35:0] D1R = {9'h101, 9'h102, 9'h103, 9'h104};
    localparam logic [35:0] HW  = {9'h014, 9'h013, 9'h012, 9'h011};
    localparam logic [35:0] BW  = {9'h024, 9'h023, 9'h022, 9'h021};
    localparam logic [35:0] P1  = {9'h134, 9'h133, 9'h132, 9'h131};
    localparam logic [35:0] P1R = {9'h131, 9'h132, 9'h133, 9'h134};
    localparam logic [35:0] P2  = {9'h144, 9'h143, 9'h142, 9'h141};
    localparam logic [35:0] P3  = {9'h154, 9'h153, 9'h152, 9'h151};
    localparam logic [35:0] P4  = {9'h164, 9'h163, 9'h162, 9'h161};

    typedef struct packed {
        logic        rd;
        logic [1:0]  ws;
        logic [35:0] wd;
        logic [35:0] pd;
        logic        e_push;
        logic        e_pop;
        logic [35:0] e_pdata;
        logic [35:0] e_rdata;
    } vec_t;

    // Modes change between complete words throughout (R12).
    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'b11, D1, 36'h0, 1'b1, 1'b0, D1,  36'h0},            // R2
        '{1'b0, 2'b10, D1, 36'h0, 1'b1, 1'b0, D1R, 36'h0},            // R3
        '{1'b0, 2'b01, {18'h0, 9'h012, 9'h011}, 36'h0, 1'b0, 1'b0, 36'h0, 36'h0}, // R4
        '{1'b0, 2'b01, {18'h0, 9'h014, 9'h013}, 36'h0, 1'b1, 1'b0, HW, 36'h0},    // R4
        '{1'b0, 2'b00, {27'h0, 9'h021}, 36'h0, 1'b0, 1'b0, 36'h0, 36'h0},         // R5
        '{1'b0, 2'b00, {27'h0, 9'h022}, 36'h0, 1'b0, 1'b0, 36'h0, 36'h0},         // R5
        '{1'b0, 2'b00, {27'h0, 9'h023}, 36'h0, 1'b0, 1'b0, 36'h0, 36'h0},         // R5
        '{1'b0, 2'b00, {27'h0, 9'h024}, 36'h0, 1'b1, 1'b0, BW, 36'h0},            // R5
        '{1'b1, 2'b11, 36'h0, P1, 1'b0, 1'b1, 36'h0, P1},                        // R6
        '{1'b1, 2'b10, 36'h0, P1, 1'b0, 1'b1, 36'h0, P1R},                       // R7
        '{1'b1, 2'b01, 36'h0, P2, 1'b0, 1'b1, 36'h0, {18'h0, 9'h142, 9'h141}},    // R8
        '{1'b1, 2'b01, 36'h0, P1, 1'b0, 1'b0, 36'h0, {18'h0, 9'h144, 9'h143}},    // R8
        '{1'b1, 2'b00, 36'h0, P3, 1'b0, 1'b1, 36'h0, {27'h0, 9'h151}},            // R8
        '{1'b1, 2'b00, 36'h0, P1, 1'b0, 1'b0, 36'h0, {27'h0, 9'h152}},            // R8
        '{1'b1, 2'b00, 36'h0, P1, 1'b0, 1'b0, 36'h0, {27'h0, 9'h153}},            // R8
        '{1'b1, 2'b00, 36'h0, P1, 1'b0, 1'b0, 36'h0, {27'h0, 9'h154}}             // R1 R8
    };

    task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One access, then an idle cycle; results sampled at falling edges.
    task automatic acc(input logic rd, input logic [1:0] ws, input logic [35:0] wd,
                       input logic full, input logic empty, input logic [35:0] pd);
        @(posedge clk);
        #1;
        strobe = 1'b1; dir_rd = rd; wsel = ws; port_wdata = wd;
        fifo_full = full; fifo_empty = empty; fifo_pop_data = pd;
        @(negedge clk);
        g_push = fifo_push; g_pop = fifo_pop; g_pdata = fifo_push_data;
        @(posedge clk);
        #1;
        strobe = 1'b0; fifo_full = 1'b0; fifo_empty = 1'b0;
        @(negedge clk);
        g_rdata = port_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        // R13: accesses during reset are refused
        @(posedge clk);
        #1;
        strobe = 1'b1; dir_rd = 1'b0; wsel = 2'b11; port_wdata = D1;
        @(negedge clk);
        chk("R13 push in reset", {35'h0, fifo_push}, 36'h0);
        @(posedge clk);
        #1;
        dir_rd = 1'b1; fifo_pop_data = P1;
        @(negedge clk);
        chk("R13 pop in reset", {35'h0, fifo_pop}, 36'h0);
        @(posedge clk);
        #1;
        strobe = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk("R13 rdata after reset", port_rdata, 36'h0);

        for (int i = 0; i < NVEC; i++) begin
            acc(VEC[i].rd, VEC[i].ws, VEC[i].wd, 1'b0, 1'b0, VEC[i].pd);
            chk($sformatf("R1 vec%0d push", i), {35'h0, g_push}, {35'h0, VEC[i].e_push});
            chk($sformatf("R6 vec%0d pop", i), {35'h0, g_pop}, {35'h0, VEC[i].e_pop});
            if (VEC[i].e_push) chk($sformatf("R4 R5 vec%0d push data", i), g_pdata, VEC[i].e_pdata);
            chk($sformatf("R8 vec%0d rdata", i), g_rdata, VEC[i].e_rdata);
        end

        // R9: interleave partial byte writes and byte reads
        acc(1'b0, 2'b00, {27'h0, 9'h031}, 1'b0, 1'b0, P1);
        acc(1'b0, 2'b00, {27'h0, 9'h032}, 1'b0, 1'b0, P1);
        chk("R9 no early push", {35'h0, g_push}, 36'h0);
        acc(1'b1, 2'b00, 36'h0, 1'b0, 1'b0, P4);
        chk("R9 read pops mid-pack", {35'h0, g_pop}, 36'h1);
        chk("R9 read lane0", g_rdata, {27'h0, 9'h161});
        acc(1'b0, 2'b00, {27'h0, 9'h033}, 1'b0, 1'b0, P1);
        acc(1'b0, 2'b00, {27'h0, 9'h034}, 1'b0, 1'b0, P1);
        chk("R9 push after interleave", {35'h0, g_push}, 36'h1);
        chk("R9 packed word intact", g_pdata, {9'h034, 9'h033, 9'h032, 9'h031});
        chk("R9 rdata kept over writes", g_rdata, {27'h0, 9'h161});
        acc(1'b1, 2'b00, 36'h0, 1'b0, 1'b0, P1);
        chk("R9 no re-pop", {35'h0, g_pop}, 36'h0);
        chk("R9 read lane1", g_rdata, {27'h0, 9'h162});
        acc(1'b1, 2'b00, 36'h0, 1'b0, 1'b0, P1);
        acc(1'b1, 2'b00, 36'h0, 1'b0, 1'b0, P1);
        chk("R9 read lane3", g_rdata, {27'h0, 9'h164});

        // R11: read needing a pop while empty is refused
        acc(1'b1, 2'b00, 36'h0, 1'b0, 1'b1, P1);
        chk("R11 no pop when empty", {35'h0, g_pop}, 36'h0);
        chk("R11 rdata unchanged", g_rdata, {27'h0, 9'h164});
        acc(1'b1, 2'b00, 36'h0, 1'b0, 1'b0, P3);
        chk("R11 retry pops", {35'h0, g_pop}, 36'h1);
        chk("R11 retry starts at lane0", g_rdata, {27'h0, 9'h151});

        // R10: completing write while full is refused, then retried
        acc(1'b0, 2'b01, {18'h0, 9'h042, 9'h041}, 1'b0, 1'b0, P1);
        acc(1'b0, 2'b01, {18'h0, 9'h044, 9'h043}, 1'b1, 1'b0, P1);
        chk("R10 no push when full", {35'h0, g_push}, 36'h0);
        acc(1'b0, 2'b01, {18'h0, 9'h044, 9'h043}, 1'b0, 1'b0, P1);
        chk("R10 retry pushes", {35'h0, g_push}, 36'h1);
        chk("R10 retry word", g_pdata, {9'h044, 9'h043, 9'h042, 9'h041});
        acc(1'b0, 2'b11, D1, 1'b1, 1'b0, P1);
        chk("R10 R2 wide write refused when full", {35'h0, g_push}, 36'h0);

        // R12: switch to reversed wide mode right after a half-word pair
        acc(1'b0, 2'b10, P2, 1'b0, 1'b0, P1);
        chk("R12 R3 reversed after mode change", g_pdata,
            {9'h141, 9'h142, 9'h143, 9'h144});

        done = 1'b1;
        finish_run();
    end
endmodule